// File: doc/BRIEF.md
# 16-bit Register Byte-Access Bridge

This block sits between an 8-bit processor bus and a set of 16-bit timer registers: one free-running counter, one capture register and a parameterised number of compare registers. Writes are made atomic by a single shared staging byte. A write to a high byte only stages it. A later write to a low byte then issues the complete 16-bit word to its target as one commit pulse.

Reads take one of two paths. The counter and the capture register can change under hardware control, so reading their low byte also captures their high byte into the staging byte. A later high-byte read then returns a value from the same instant. Compare registers change only on processor writes, so both of their bytes are read straight from the live value.

The bus has separate write and read strobes, and both may be active in the same cycle. No ready signal exists on either side. Every access is taken in the cycle it is presented. Read data returns one cycle later with a one-cycle valid pulse. Every commit pulse must be accepted by the register it selects in the cycle it appears.

Top module: `wide_reg_byte_bridge`

## Requirements
- R1: After reset the staging byte is 0, `commit_stb` is all zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: A write whose address has bit 0 set (high lane) to a mapped target loads `wr_data` into the staging byte and raises no commit strobe.
- R3: A write with address bit 0 clear (low lane) to mapped target index i = `addr[AW-1:1]` raises only `commit_stb[i]` for exactly the next cycle, with `commit_word` = {staging byte as it was in the write cycle, `wr_data`}. Index 0 is the counter, 1 is the capture register and 2 and up are the compare registers.
- R4: The staging byte is shared: a high-lane write to one target followed by a low-lane write to another commits the staged byte to the second target.
- R5: A commit does not clear the staging byte, and a cycle with neither strobe leaves it unchanged, so repeated low-lane writes reuse the last staged byte.
- R6: A read of either lane of a compare register returns that byte of its live `tgt_val` word and leaves the staging byte unchanged.
- R7: A low-lane read of the counter or capture register returns the live low byte and loads the live high byte into the staging byte; a high-lane read of either returns the staging byte.
- R8: `rd_valid` pulses for the cycle after each `rd_en`, `rd_data` appears in that same cycle, and `rd_data` holds its value while no read is made.
- R9: In one cycle a high-lane write takes priority over a read latch for the staging byte, and a read or commit in that cycle uses the staging byte as it was before the cycle.
- R10: Addresses whose index is at or above the number of targets are unmapped: writes to them change nothing and raise no strobe, and reads of them return 0 with `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | AW | Write address {target index, lane} |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | AW | Read address {target index, lane} |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data pulse, one cycle after rd_en |
| tgt_val | input | 16*NTGT | Live values of all targets, target i in bits [16i+15:16i] |
| commit_stb | output | NTGT | One-cycle write pulse, bit i for target i |
| commit_word | output | 16 | 16-bit value being committed |

## Verification
The staging byte can be loaded by a high-lane write and by a low-lane counter or capture read in the same cycle. It can also be consumed in that cycle by a commit or by a high-lane read. The bench provokes these collisions with directed pairs: a staging write beside a latching read, a staging write beside a high-lane read, and a commit beside a latching read. Random cycles then set both strobes independently. Each result is judged against a bench model in which the write wins the staging byte and every consumer sees the byte from before the cycle.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;
  // target indices below this are hardware-updated (counter, capture)
  localparam int unsigned HW_TARGETS = 2;
endpackage

// File: rtl/wbb_decode.sv
module wbb_decode
  import wbb_pkg::*;
#(
  parameter int unsigned NTGT = 5,
  parameter int unsigned AW   = $clog2(NTGT) + 1,
  localparam int unsigned IW  = AW - 1
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] idx,
  output lane_e         lane,
  output logic          mapped
);
  localparam logic [IW-1:0] LAST = IW'(NTGT - 1);

  always_comb begin
    idx    = addr[AW-1:1];
    lane   = lane_e'(addr[0]);
    mapped = (addr[AW-1:1] <= LAST);
  end
endmodule

// File: rtl/wbb_stage.sv
module wbb_stage #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic [BW-1:0] wr_byte,
  input  logic          ld_rd,
  input  logic [BW-1:0] rd_byte,
  output logic [BW-1:0] temp
);
  // a staging write outranks a read latch in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      temp <= '0;
    else if (ld_wr)  temp <= wr_byte;
    else if (ld_rd)  temp <= rd_byte;
  end

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> temp == $past(wr_byte)); // R9
  AST_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rd && !ld_wr) |=> temp == $past(rd_byte)); // R7
endmodule

// File: rtl/wbb_commit.sv
module wbb_commit #(
  parameter int unsigned NTGT = 5,
  parameter int unsigned BW   = 8,
  parameter int unsigned IW   = 3,
  localparam int unsigned WW  = 2 * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [IW-1:0]   idx,
  input  logic [BW-1:0]   temp,
  input  logic [BW-1:0]   wr_byte,
  output logic [NTGT-1:0] stb,
  output logic [WW-1:0]   word
);
  for (genvar g = 0; g < NTGT; g++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb[g] <= 1'b0;
      else        stb[g] <= fire && (idx == IW'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (fire) word <= {temp, wr_byte};
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R3
  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != '0) |-> $past(fire)); // R3
  AST_COMMIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != '0) |-> word[WW-1:BW] == $past(temp)); // R4
endmodule

// File: rtl/wbb_readmux.sv
module wbb_readmux
  import wbb_pkg::*;
#(
  parameter int unsigned NTGT = 5,
  parameter int unsigned BW   = 8,
  parameter int unsigned IW   = 3,
  localparam int unsigned WW  = 2 * BW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IW-1:0]      idx,
  input  lane_e              lane,
  input  logic               mapped,
  input  logic [NTGT*WW-1:0] tgt_val,
  input  logic [BW-1:0]      temp,
  output logic               ld_rd,
  output logic [BW-1:0]      latch_byte,
  output logic [BW-1:0]      rdata,
  output logic               rvalid
);
  logic [WW-1:0] words [NTGT];
  logic [WW-1:0] sel;
  logic [IW-1:0] idx_safe;
  logic          hw;
  logic [BW-1:0] rbyte;

  for (genvar g = 0; g < NTGT; g++) begin : g_words
    assign words[g] = tgt_val[g*WW +: WW];
  end

  always_comb begin
    idx_safe   = mapped ? idx : '0;
    sel        = words[idx_safe];
    hw         = mapped && (idx < IW'(HW_TARGETS));
    latch_byte = sel[WW-1:BW];
    ld_rd      = rd_en && hw && (lane == LANE_LO);
    if (!mapped)               rbyte = '0;
    else if (lane == LANE_LO)  rbyte = sel[BW-1:0];
    else if (hw)               rbyte = temp;
    else                       rbyte = sel[WW-1:BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rbyte;
    end
  end

  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> rdata == '0); // R10
endmodule

// File: rtl/wide_reg_byte_bridge.sv
module wide_reg_byte_bridge
  import wbb_pkg::*;
#(
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned BW      = 8,
  localparam int unsigned NTGT   = NUM_CMP + HW_TARGETS,
  localparam int unsigned WW     = 2 * BW,
  localparam int unsigned AW     = $clog2(NTGT) + 1,
  localparam int unsigned IW     = AW - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [BW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [BW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic [NTGT*WW-1:0] tgt_val,
  output logic [NTGT-1:0]    commit_stb,
  output logic [WW-1:0]      commit_word
);
  logic [IW-1:0] w_idx, r_idx;
  lane_e         w_lane, r_lane;
  logic          w_mapped, r_mapped;
  logic [BW-1:0] temp, latch_byte;
  logic          ld_wr, ld_rd, fire;

  wbb_decode #(.NTGT(NTGT), .AW(AW)) u_wdec (
    .addr(wr_addr), .idx(w_idx), .lane(w_lane), .mapped(w_mapped));
  wbb_decode #(.NTGT(NTGT), .AW(AW)) u_rdec (
    .addr(rd_addr), .idx(r_idx), .lane(r_lane), .mapped(r_mapped));

  always_comb begin
    ld_wr = wr_en && w_mapped && (w_lane == LANE_HI);
    fire  = wr_en && w_mapped && (w_lane == LANE_LO);
  end

  wbb_stage #(.BW(BW)) u_stage (
    .clk(clk), .rst_n(rst_n), .ld_wr(ld_wr), .wr_byte(wr_data),
    .ld_rd(ld_rd), .rd_byte(latch_byte), .temp(temp));

  wbb_commit #(.NTGT(NTGT), .BW(BW), .IW(IW)) u_commit (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(w_idx), .temp(temp),
    .wr_byte(wr_data), .stb(commit_stb), .word(commit_word));

  wbb_readmux #(.NTGT(NTGT), .BW(BW), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .idx(r_idx), .lane(r_lane),
    .mapped(r_mapped), .tgt_val(tgt_val), .temp(temp), .ld_rd(ld_rd),
    .latch_byte(latch_byte), .rdata(rd_data), .rvalid(rd_valid));

  AST_HI_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0]) |=> commit_stb == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(temp)); // R5
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_mapped && !rd_en) |=> ($stable(temp) && commit_stb == '0)); // R10
endmodule

// File: tb/wide_reg_byte_bridge_tb.sv
module wide_reg_byte_bridge_tb;
  localparam int NUM_CMP = 3;
  localparam int BW = 8;
  localparam int WW = 16;
  localparam int NTGT = NUM_CMP + 2;
  localparam int AW = $clog2(NTGT) + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic               wr_en, rd_en;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [BW-1:0]      wr_data, rd_data;
  logic               rd_valid;
  logic [NTGT*WW-1:0] tgt_val, cur_tv;
  logic [NTGT-1:0]    commit_stb;
  logic [WW-1:0]      commit_word;

  wide_reg_byte_bridge #(.NUM_CMP(NUM_CMP), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .tgt_val(tgt_val), .commit_stb(commit_stb),
    .commit_word(commit_word));

  int n_vec = 0;
  int n_bad = 0;
  logic [BW-1:0]   m_temp, m_rdata;
  logic [NTGT-1:0] e_stb;
  logic [WW-1:0]   e_word;
  logic            e_rvalid;
  string           tag_w, tag_r;

  function automatic logic [BW-1:0] f_read(input logic [AW-1:0] a,
      input logic [BW-1:0] tmp, input logic [NTGT*WW-1:0] tv);
    int i = int'(a >> 1);
    logic [WW-1:0] w;
    if (i >= NTGT) return '0;
    w = tv[i*WW +: WW];
    if (!a[0]) return w[BW-1:0];
    if (i < 2) return tmp;
    return w[WW-1:BW];
  endfunction

  function automatic string f_rtag(input logic [AW-1:0] a);
    int i = int'(a >> 1);
    if (i >= NTGT) return "R10";
    if (i < 2) return "R7";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [AW-1:0] wa,
      input logic [BW-1:0] wd, input logic re, input logic [AW-1:0] ra,
      input string tag);
    int wi = int'(wa >> 1);
    int ri = int'(ra >> 1);
    logic [BW-1:0] nt;
    @(negedge clk);
    check(tag_w, "commit_stb", 32'(commit_stb), 32'(e_stb));
    if (e_stb != '0) check(tag_w, "commit_word", 32'(commit_word), 32'(e_word));
    check(tag_r, "rd_valid", 32'(rd_valid), 32'(e_rvalid));
    check(tag_r, "rd_data", 32'(rd_data), 32'(m_rdata));
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; tgt_val = cur_tv;
    // expectations for the cycle after this edge
    e_stb = '0;
    if (we && wi < NTGT && !wa[0]) begin
      e_stb = NTGT'(1) << wi;
      e_word = {m_temp, wd};
    end
    e_rvalid = re;
    if (re) m_rdata = f_read(ra, m_temp, cur_tv);
    nt = m_temp;
    if (we && wi < NTGT && wa[0]) nt = wd;
    else if (re && ri < 2 && !ra[0]) nt = cur_tv[ri*WW + BW +: BW];
    m_temp = nt;
    if (tag != "") begin
      tag_w = tag; tag_r = tag;
    end else begin
      tag_w = !we ? "R5" : (wi >= NTGT) ? "R10" : wa[0] ? "R2" : "R3";
      tag_r = re ? f_rtag(ra) : "R8";
    end
  endtask

  task automatic set_tv(input int i, input logic [WW-1:0] v);
    cur_tv[i*WW +: WW] = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0;
    wr_data = '0; cur_tv = '0; tgt_val = '0;
    m_temp = '0; m_rdata = '0; e_stb = '0; e_word = '0; e_rvalid = 0;
    tag_w = "R1"; tag_r = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a high counter read exposes the cleared staging byte
    set_tv(0, 16'hA5C3);
    step(0, 0, 0, 1, 1, "R1");
    // R2, R3: stage then commit to compare 0
    step(1, 5, 8'hAB, 0, 0, "R2");
    step(1, 4, 8'hCD, 0, 0, "R3");
    // R4: stage via compare 1, commit to counter
    step(1, 7, 8'h12, 0, 0, "R4");
    step(1, 0, 8'h34, 0, 0, "R4");
    // R5: reuse the staged byte without a new high write
    step(0, 0, 0, 0, 0, "R5");
    step(1, 2, 8'h56, 0, 0, "R5");
    // R7: coherent counter read across a value change
    set_tv(0, 16'hBEEF);
    step(0, 0, 0, 1, 0, "R7");
    set_tv(0, 16'h0000);
    step(0, 0, 0, 1, 1, "R7");
    // R6: compare reads are direct and leave the staging byte alone
    set_tv(3, 16'h9A7B);
    step(0, 0, 0, 1, 6, "R6");
    step(0, 0, 0, 1, 7, "R6");
    step(0, 0, 0, 1, 1, "R6");
    // R8: no read, data holds
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // R9: write-high beside a latching read, then beside a high read
    set_tv(0, 16'h9911);
    step(1, 9, 8'h77, 1, 0, "R9");
    step(1, 9, 8'h88, 1, 1, "R9");
    step(0, 0, 0, 1, 1, "R9");
    // R9: commit beside a latching capture read
    set_tv(1, 16'h4400);
    step(1, 4, 8'h01, 1, 2, "R9");
    step(0, 0, 0, 1, 3, "R9");
    // R10: unmapped writes and reads
    step(1, 15, 8'hEE, 0, 0, "R10");
    step(1, 10, 8'hEE, 1, 12, "R10");
    step(0, 0, 0, 1, 1, "R10");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      for (int t = 0; t < NTGT; t++)
        if ($urandom % 4 == 0) set_tv(t, WW'($urandom));
      step(1'($urandom), AW'($urandom), BW'($urandom),
           1'($urandom), AW'($urandom), "");
    end
    step(0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, "");
    summary();
    $finish;
  end
endmodule